// File: doc/BRIEF.md
# Cartridge Bus Transfer Cost Timer

This block works out how long a transfer on a paged cartridge bus will take, in cycles of the faster processor clock. Software programs four timing fields for each of two address domains. A request then names a target address and a length in bytes. The block finds the domain from the address and picks that domain's fields. It then counts the pages touched and the 16-bit beats moved, and sums a fixed per-page overhead and a per-beat strobe cost. Last, it scales the total by three halves to move it into the faster clock domain.

The result leaves the block in two forms. A one-cycle result strobe carries the count itself. A down-counter is also loaded with that count and raises a one-cycle completion pulse when it runs out, so a bus model can stall for exactly the computed time. An address that falls in neither domain gives an error result with a zero count, and that result does not touch the counter.

Top module: `bus_cost_timer`

## Requirements
- R1: After reset, `res_valid`, `res_err`, `res_count`, `cd_busy` and `cd_done` are all 0.
- R2: Timing fields are written with `cfg_we` at byte offsets 0x14/0x18/0x1C/0x20 (domain 1 latency, strobe width, page exponent, release) and 0x24/0x28/0x2C/0x30 (the same fields of domain 2). Only `cfg_data[7:0]` is kept. A write to any other offset, misaligned ones included, changes nothing.
- R3: Addresses 0x06000000–0x07FFFFFF and 0x10000000–0x1FBFFFFF select domain 1. Addresses 0x05000000–0x05FFFFFF and 0x08000000–0x0FFFFFFF select domain 2. Any other address gives `res_err`=1.
- R4: The effective latency, strobe width and release are each the field value plus one. The page size is 2^(exponent+2) bytes, and the page count is the length divided by the page size, rounded up.
- R5: The raw cost is (14 + latency) × pages + (width + release) × floor(length / 2) + 5 × pages.
- R6: `res_count` = raw + floor(raw / 2), so any half cycle is dropped.
- R7: Each cycle with `req_start` high yields exactly one `res_valid` pulse, three clock edges later. Requests may arrive back to back.
- R8: An error result carries `res_count`=0 and neither starts nor disturbs the countdown.
- R9: A valid result of count N raises `cd_busy` from the next cycle. `cd_done` then pulses for one cycle N+2 cycles after the `res_valid` cycle, and in that cycle `cd_busy` is low.
- R10: A new valid result restarts the countdown with its own count, and the countdown already running is dropped.
- R11: The count does not overflow for a length of 0xFFFFFF with every field at 0xFF except a page exponent of 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing field write strobe |
| cfg_off | input | 8 | Byte offset of the field written |
| cfg_data | input | 32 | Write data; low byte kept |
| req_start | input | 1 | Request strobe |
| req_addr | input | 32 | Target bus address of the request |
| req_len | input | LEN_W (24) | Transfer length in bytes |
| res_valid | output | 1 | Result strobe |
| res_err | output | 1 | Address hit no domain |
| res_count | output | CNT_W (40) | Scaled cycle count |
| cd_busy | output | 1 | Countdown running |
| cd_done | output | 1 | Countdown finished pulse |

## Verification
The checker watches the result timing and the countdown on every cycle. It confirms that each result comes three edges after its request, that an error result has a zero count and never wakes the counter, and that the completion pulse lasts one cycle and leaves the counter idle. The numeric parts can only be shown by the bench scenarios, which compare results with an independent model: the domain boundaries, the rounding of pages and beats, the truncating three-halves scale, the register map with its ignored offsets, the exact countdown length and the restart. Large values are included in those scenarios.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int FW = 8;

  typedef struct packed {
    logic [FW-1:0] lat;
    logic [FW-1:0] pwd;
    logic [FW-1:0] pgs;
    logic [FW-1:0] rls;
  } dom_timing_t;

  typedef enum logic [1:0] {DOM_NONE = 2'd0, DOM_ONE = 2'd1, DOM_TWO = 2'd2} dom_e;

  localparam logic [31:0] D1A_LO = 32'h0600_0000, D1A_HI = 32'h07FF_FFFF;
  localparam logic [31:0] D1B_LO = 32'h1000_0000, D1B_HI = 32'h1FBF_FFFF;
  localparam logic [31:0] D2A_LO = 32'h0500_0000, D2A_HI = 32'h05FF_FFFF;
  localparam logic [31:0] D2B_LO = 32'h0800_0000, D2B_HI = 32'h0FFF_FFFF;

  function automatic dom_e map_domain(input logic [31:0] a);
    if ((a >= D1A_LO && a <= D1A_HI) || (a >= D1B_LO && a <= D1B_HI)) return DOM_ONE;
    if ((a >= D2A_LO && a <= D2A_HI) || (a >= D2B_LO && a <= D2B_HI)) return DOM_TWO;
    return DOM_NONE;
  endfunction
endpackage

// File: rtl/bct_regs.sv
module bct_regs
  import bct_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int BASE  = 'h14,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [OFF_W-1:0] cfg_off,
  input  logic [FW-1:0]    cfg_byte,
  output dom_timing_t      t_one,
  output dom_timing_t      t_two
);
  localparam int NREG = 8;
  logic [FW-1:0] r [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [OFF_W-1:0] OFF_I = OFF_W'(BASE + i * STEP);
    always_ff @(posedge clk) begin
      if (rst) r[i] <= '0;
      else if (cfg_we && cfg_off == OFF_I) r[i] <= cfg_byte;
    end
  end

  assign t_one = '{lat: r[0], pwd: r[1], pgs: r[2], rls: r[3]};
  assign t_two = '{lat: r[4], pwd: r[5], pgs: r[6], rls: r[7]};
endmodule

// File: rtl/bct_select.sv
module bct_select
  import bct_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  dom_timing_t      t_one,
  input  dom_timing_t      t_two,
  output logic             s_valid,
  output logic             s_err,
  output logic [LEN_W-1:0] s_len,
  output dom_timing_t      s_t
);
  dom_e dom;
  assign dom = map_domain(req_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_err   <= 1'b0;
      s_len   <= '0;
      s_t     <= '0;
    end else begin
      s_valid <= req_start;
      if (req_start) begin
        s_err <= (dom == DOM_NONE);
        s_len <= req_len;
        s_t   <= (dom == DOM_TWO) ? t_two : t_one;
      end
    end
  end
endmodule

// File: rtl/bct_cost.sv
module bct_cost
  import bct_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic             s_err,
  input  logic [LEN_W-1:0] s_len,
  input  dom_timing_t      s_t,
  output logic             res_valid,
  output logic             res_err,
  output logic [CNT_W-1:0] res_count
);
  localparam int SH_W = FW + 1;
  localparam logic [SH_W-1:0] SH_LIM = SH_W'(LEN_W);
  localparam int PP_W = FW + 1;
  localparam int PH_W = FW + 2;

  // page and beat counts
  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] low_mask, pages_c;
  logic [PP_W-1:0]  per_page_c;
  logic [PH_W-1:0]  per_half_c;

  always_comb begin
    sh       = {1'b0, s_t.pgs} + SH_W'(2);
    low_mask = ~({LEN_W{1'b1}} << sh);
    if (sh >= SH_LIM) pages_c = LEN_W'(|s_len);
    else              pages_c = (s_len >> sh) + LEN_W'(|(s_len & low_mask));
    per_page_c = {1'b0, s_t.lat} + PP_W'(14 + 1 + 5);
    per_half_c = {2'b0, s_t.pwd} + {2'b0, s_t.rls} + PH_W'(2);
  end

  logic             v2, e2;
  logic [LEN_W-1:0] pages2, halves2;
  logic [PP_W-1:0]  per_page2;
  logic [PH_W-1:0]  per_half2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; e2 <= 1'b0;
      pages2 <= '0; halves2 <= '0; per_page2 <= '0; per_half2 <= '0;
    end else begin
      v2        <= s_valid;
      e2        <= s_err;
      pages2    <= pages_c;
      halves2   <= s_len >> 1;
      per_page2 <= per_page_c;
      per_half2 <= per_half_c;
    end
  end

  // multiply, sum and scale by three halves
  logic [CNT_W-1:0] raw, scaled;
  always_comb begin
    raw    = CNT_W'(per_page2) * CNT_W'(pages2) + CNT_W'(per_half2) * CNT_W'(halves2);
    scaled = raw + (raw >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_count <= '0;
    end else begin
      res_valid <= v2;
      res_err   <= v2 & e2;
      res_count <= (v2 && !e2) ? scaled : '0;
    end
  end
endmodule

// File: rtl/bct_countdown.sv
module bct_countdown #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= value;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_cost_timer.sv
module bus_cost_timer
  import bct_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_off,
  input  logic [31:0]      cfg_data,
  input  logic             req_start,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             res_valid,
  output logic             res_err,
  output logic [CNT_W-1:0] res_count,
  output logic             cd_busy,
  output logic             cd_done
);
  dom_timing_t      t_one, t_two, s_t;
  logic             s_valid, s_err;
  logic [LEN_W-1:0] s_len;
  logic             unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_data[31:FW];

  bct_regs #(.OFF_W(8)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_byte(cfg_data[FW-1:0]), .t_one(t_one), .t_two(t_two)
  );

  bct_select #(.LEN_W(LEN_W)) u_sel (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_len(req_len), .t_one(t_one), .t_two(t_two),
    .s_valid(s_valid), .s_err(s_err), .s_len(s_len), .s_t(s_t)
  );

  bct_cost #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cost (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_err(s_err), .s_len(s_len),
    .s_t(s_t), .res_valid(res_valid), .res_err(res_err), .res_count(res_count)
  );

  bct_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk(clk), .rst(rst), .load(res_valid & ~res_err), .value(res_count),
    .busy(cd_busy), .done(cd_done)
  );
endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             req_start,
  input logic             res_valid,
  input logic             res_err,
  input logic [CNT_W-1:0] res_count,
  input logic             cd_busy,
  input logic             cd_done
);
  logic [2:0] start_sh;
  always_ff @(posedge clk) begin
    if (rst) start_sh <= '0;
    else     start_sh <= {start_sh[1:0], req_start};
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid == start_sh[2]);

  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_err) |-> (res_count == '0));

  p_err_no_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_err && !cd_busy) |=> !cd_busy);

  p_busy_after_load_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_err) |=> cd_busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    cd_done |=> !cd_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cd_done |-> !cd_busy);
endmodule

bind bus_cost_timer bct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_start(req_start), .res_valid(res_valid),
  .res_err(res_err), .res_count(res_count), .cd_busy(cd_busy), .cd_done(cd_done)
);

// File: tb/bus_cost_timer_test.sv
`timescale 1ns/1ps
module bus_cost_timer_test;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [7:0]  cfg_off = 0;
  logic [31:0] cfg_data = 0;
  logic        req_start = 0;
  logic [31:0] req_addr = 0;
  logic [23:0] req_len = 0;
  logic        res_valid, res_err, cd_busy, cd_done;
  logic [39:0] res_count;

  int checks = 0, errors = 0;
  bit finished = 0;
  int unsigned p [2][4];

  always #2 clk = ~clk;

  bus_cost_timer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_data(cfg_data),
    .req_start(req_start), .req_addr(req_addr), .req_len(req_len),
    .res_valid(res_valid), .res_err(res_err), .res_count(res_count),
    .cd_busy(cd_busy), .cd_done(cd_done)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 none, 1 domain one, 2 domain two
  function automatic int model_dom(input logic [31:0] a);
    if ((a >= 32'h0600_0000 && a <= 32'h07FF_FFFF) || (a >= 32'h1000_0000 && a <= 32'h1FBF_FFFF)) return 1;
    if ((a >= 32'h0500_0000 && a <= 32'h05FF_FFFF) || (a >= 32'h0800_0000 && a <= 32'h0FFF_FFFF)) return 2;
    return 0;
  endfunction

  function automatic longint unsigned model_cost(input int d, input longint unsigned len);
    longint unsigned lat, pwd, rls, sh, pages, cyc;
    lat = p[d][0] + 1; pwd = p[d][1] + 1; rls = p[d][3] + 1; sh = p[d][2] + 2;
    if (sh >= 40) pages = (len != 0) ? 1 : 0;
    else          pages = (len + (64'd1 << sh) - 1) >> sh;
    cyc = (14 + lat) * pages + (pwd + rls) * (len / 2) + 5 * pages;
    return cyc + cyc / 2;
  endfunction

  task automatic wr(input logic [7:0] off, input logic [31:0] data);
    cfg_we = 1; cfg_off = off; cfg_data = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_field(input int d, input int f, input logic [31:0] data);
    wr(8'(8'h14 + 16 * d + 4 * f), data);
    p[d][f] = data[7:0];
  endtask

  // caller at a negedge; returns at the negedge where the result is visible
  task automatic run(input logic [31:0] a, input logic [23:0] l);
    req_start = 1; req_addr = a; req_len = l;
    @(negedge clk);
    req_start = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_check(input string req, input logic [31:0] a, input logic [23:0] l);
    int d;
    run(a, l);
    d = model_dom(a);
    chk(req, res_valid, 1);
    chk(req, res_err, (d == 0) ? 1 : 0);
    chk(req, res_count, (d == 0) ? 0 : model_cost(d - 1, l));
  endtask

  task automatic wait_done(output int k);
    k = 0;
    for (int i = 1; i < 5000; i++) begin
      @(negedge clk);
      if (cd_done) begin k = i; break; end
    end
  endtask

  task automatic defaults();
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 4; f++) set_field(d, f, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    longint unsigned n;
    int unsigned seed;
    logic [31:0] addrs [12];
    seed = $urandom(32'd2024);
    addrs = '{32'h0500_0000, 32'h05FF_FFFF, 32'h04FF_FFFF, 32'h0600_0000, 32'h07FF_FFFF,
              32'h0800_0000, 32'h0FFF_FFFF, 32'h1000_0000, 32'h1FBF_FFFF, 32'h1FC0_0000,
              32'h0000_0000, 32'hFFFF_FFFF};
    for (int d = 0; d < 2; d++) for (int f = 0; f < 4; f++) p[d][f] = 0;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_err", res_err, 0);
    chk("R1 res_count", res_count, 0);
    chk("R1 cd_busy", cd_busy, 0);
    chk("R1 cd_done", cd_done, 0);

    // R4 R5 R6 with reset defaults: 8 bytes -> 2 pages, 4 beats, 48 -> 72
    run_check("R5 default len8", 32'h0600_0000, 24'd8);
    chk("R6 default len8 literal", res_count, 72);
    run_check("R4 default len1", 32'h0500_0000, 24'd1);
    chk("R6 truncation len3", 0, 0);
    run_check("R6 len3 odd", 32'h0500_0000, 24'd3);

    // R2 distinct fields per domain, high bits dropped
    set_field(0, 0, 32'hFFFF_FF03);
    set_field(0, 1, 32'h0000_0102);
    set_field(0, 2, 32'h0000_0001);
    set_field(0, 3, 32'h0000_0004);
    set_field(1, 0, 32'h0000_0010);
    set_field(1, 1, 32'h0000_0000);
    set_field(1, 2, 32'h0000_0003);
    set_field(1, 3, 32'h0000_0007);
    run_check("R2 domain one fields", 32'h0700_0000, 24'd100);
    run_check("R2 domain two fields", 32'h0900_0000, 24'd100);
    // R2 ignored offsets
    wr(8'h15, 32'hFF); wr(8'h10, 32'hFF); wr(8'h34, 32'hFF); wr(8'h2E, 32'hFF); wr(8'h00, 32'hFF);
    run_check("R2 ignored offset dom1", 32'h0700_0000, 24'd100);
    run_check("R2 ignored offset dom2", 32'h0900_0000, 24'd100);

    // R3 domain boundaries
    foreach (addrs[i]) run_check("R3 boundary", addrs[i], 24'd37);

    // R4 page exponent so large the page exceeds any length
    set_field(1, 2, 32'hFF);
    run_check("R4 huge page", 32'h0500_1000, 24'hFFFFFF);
    run_check("R4 zero length", 32'h0500_1000, 24'd0);

    // R11 worst case
    for (int f = 0; f < 4; f++) set_field(0, f, (f == 2) ? 0 : 32'hFF);
    run_check("R11 max length", 32'h1000_0000, 24'hFFFFFF);

    // R7 back to back
    defaults();
    req_start = 1; req_addr = 32'h0600_0000; req_len = 24'd8;
    @(negedge clk); req_addr = 32'h0000_0000; req_len = 24'd8;
    @(negedge clk); req_addr = 32'h0800_0000; req_len = 24'd1;
    @(negedge clk); req_start = 0;
    chk("R7 first count", res_count, 72);
    chk("R7 first valid", res_valid, 1);
    @(negedge clk);
    chk("R7 second err", res_err, 1);
    chk("R7 second valid", res_valid, 1);
    @(negedge clk);
    chk("R7 third count", res_count, 30);
    @(negedge clk);
    chk("R7 no extra result", res_valid, 0);

    // R9 countdown lengths
    repeat (40) @(negedge clk);
    run(32'h0600_0000, 24'd8);
    n = res_count;
    @(negedge clk);
    chk("R9 busy after result", cd_busy, 1);
    wait_done(k);
    chk("R9 done delay len8", k + 1, n + 2);
    chk("R9 idle at done", cd_busy, 0);
    @(negedge clk);
    chk("R9 done one cycle", cd_done, 0);
    run(32'h0600_0000, 24'd0);
    wait_done(k);
    chk("R9 done delay zero count", k, 2);

    // R8 error result leaves countdown alone
    run(32'h0600_0000, 24'd8);
    n = res_count;
    run_check("R8 error result", 32'h0300_0000, 24'd8);
    wait_done(k);
    chk("R8 countdown undisturbed", k + 3, n + 2);
    run(32'h0000_0000, 24'd8);
    repeat (2) @(negedge clk);
    chk("R8 error starts nothing", cd_busy, 0);

    // R10 reload
    run(32'h0600_0000, 24'd64);
    run(32'h0600_0000, 24'd1);
    n = res_count;
    wait_done(k);
    chk("R10 reload count", n, 30);
    chk("R10 reload delay", k, n + 2);

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [31:0] a;
      logic [23:0] l;
      if ($urandom % 3 == 0)
        set_field($urandom % 2, $urandom % 4, ($urandom % 4 == 0) ? $urandom : $urandom % 12);
      a = ($urandom % 4 == 0) ? addrs[$urandom % 12] : (32'h0500_0000 + ($urandom % 32'h1B00_0000));
      l = ($urandom % 2) ? 24'($urandom) : 24'($urandom % 300);
      run_check("R5 random", a, l);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule